// File: doc/BRIEF.md
# Watch Interval Timer with Tone Output

The block is a free-running watch timer. A prescaler turns the system clock into a slow tick, and a binary divider chain counts those ticks. The chain serves two purposes. It raises a sticky interval request at one of two programmable periods, a long one for watch-time keeping and a short one for fine real-time measurement. It also supplies four square-wave taps, one of which is routed to a buzzer pin.

With the default parameters and a 4.19 MHz system clock, the tick runs at about 32.8 kHz. The long interval is then 0.5 s (16384 ticks) and the short interval about 3.91 ms (128 ticks). The four tones are near 1, 2, 4 and 8 kHz.

Software controls the block through one 8-bit mode register. The register holds a run bit, an interval select, a two-bit tone select and a write-only restart bit that clears the divider. The request flag is a quasi-interrupt: it stays set until it is cleared through its own clear input.

Top module: `watch_buzzer_timer`

## Requirements
- R1: After reset, the mode readback is 0x00, `wt_req` is 0 and `buzz` is 0.
- R2: A write stores mode bits [6:0], and `mode_rdata` returns them from the next cycle. Bit 0 is run, bit 1 is the short-interval select, bits [3:2] are the tone select, and bits [6:4] are reserved: they are stored and read back but have no effect.
- R3: While run (bit 0) is 0, the prescaler and divider hold their counts, no request is raised and `buzz` is 0. Setting run again resumes counting from the held state.
- R4: The divider chain advances by one tick for every PRE_DIV system clocks during which run is 1.
- R5: With bit 1 at 0, the request sets once every 2^CHAIN_W ticks. Measured from a restart write, it sets on the (2^CHAIN_W * PRE_DIV)-th clock edge after the write edge.
- R6: With bit 1 at 1, the request sets once every 2^SHORT_LOG2 ticks.
- R7: Tone select t (0..3) drives `buzz` as a square wave. The period is 2^(TAP_LO+4-t) ticks, and the high time is half the period. Tone select 3 gives the highest frequency.
- R8: Writing bit 7 as 1 clears the prescaler and the divider chain on the write edge. Bit 7 is not stored and reads as 0.
- R9: `wt_req` stays at 1 until `wt_req_clr` is high at a clock edge; it then returns to 0.
- R10: When an interval expiry and `wt_req_clr` fall in the same cycle, the request is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| mode_rdata | output | 8 | Mode register readback |
| wt_req_clr | input | 1 | Clears the interval request |
| wt_req | output | 1 | Sticky interval request flag |
| buzz | output | 1 | Buzzer square-wave output |

## Verification
The assertions assume that `rst` is applied for at least one clock before any checked behaviour. They also assume that the mode and clear inputs are steady at each clock edge, so that each write and each clear is one clean single-cycle strobe. The bench drives all inputs at the falling clock edge and holds each strobe for exactly one cycle. Its seeded random section chooses only legal tone and interval codes. Every restart in that section follows a flag clear, so each expected expiry edge is exact.

// File: rtl/wt_pkg.sv
package wt_pkg;

  localparam int MODE_W    = 8;
  localparam int RUN_BIT   = 0;
  localparam int SHORT_BIT = 1;
  localparam int TONE_LO   = 2;
  localparam int RESTART_B = 7;
  localparam int TONES     = 4;

  typedef struct packed {
    logic [2:0] spare;
    logic [1:0] tone;
    logic       short_sel;
    logic       run;
  } wt_mode_t;

  function automatic wt_mode_t unpack_mode(input logic [MODE_W-1:0] d);
    wt_mode_t m;
    m.run       = d[RUN_BIT];
    m.short_sel = d[SHORT_BIT];
    m.tone      = d[TONE_LO+1:TONE_LO];
    m.spare     = d[6:4];
    return m;
  endfunction

endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
  parameter int PRE_DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = en && (cnt_q == LAST);

  // R4: count never leaves its modulus
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R3: stopped prescaler holds its state
  a_r3_pre_frozen: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/wt_chain.sv
module wt_chain #(
  parameter int CHAIN_W    = 14,
  parameter int SHORT_LOG2 = 7,
  parameter int TAP_LO     = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       clr,
  output logic       long_evt,
  output logic       short_evt,
  output logic [3:0] taps
);
  logic [CHAIN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  assign long_evt  = tick && (&cnt_q);
  assign short_evt = tick && (&cnt_q[SHORT_LOG2-1:0]);

  // taps[0] is the slowest stage, taps[3] the fastest
  for (genvar g = 0; g < 4; g++) begin : g_tap
    assign taps[g] = cnt_q[TAP_LO + 3 - g];
  end

  // R4: one step per tick
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> (cnt_q - $past(cnt_q)) == CHAIN_W'(1));

  // R3: no tick, no movement
  a_r3_chain_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt_q));

  // R8: restart empties the chain
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt_q == '0);

endmodule

// File: rtl/wt_tone_mux.sv
module wt_tone_mux (
  input  logic       run,
  input  logic [1:0] tone,
  input  logic [3:0] taps,
  output logic       buzz
);
  always_comb begin
    buzz = 1'b0;
    if (run) buzz = taps[tone];
  end
endmodule

// File: rtl/wt_req_flag.sv
module wt_req_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R10: set beats clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);

  // R9: flag is sticky
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

  // R9: clear without set drops the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);

endmodule

// File: rtl/watch_buzzer_timer.sv
module watch_buzzer_timer #(
  parameter int PRE_DIV    = 128,
  parameter int CHAIN_W    = 14,
  parameter int SHORT_LOG2 = 7,
  parameter int TAP_LO     = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_we,
  input  logic [7:0] mode_wdata,
  output logic [7:0] mode_rdata,
  input  logic       wt_req_clr,
  output logic       wt_req,
  output logic       buzz
);
  import wt_pkg::*;

  wt_mode_t   mode_q;
  logic       restart;
  logic       tick;
  logic       long_evt, short_evt, evt;
  logic [3:0] taps;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_we) mode_q <= unpack_mode(mode_wdata);
  end

  assign restart    = mode_we && mode_wdata[RESTART_B];
  assign mode_rdata = {1'b0, mode_q};

  wt_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .en(mode_q.run), .clr(restart), .tick(tick));

  wt_chain #(.CHAIN_W(CHAIN_W), .SHORT_LOG2(SHORT_LOG2), .TAP_LO(TAP_LO)) u_chain (
    .clk(clk), .rst(rst), .tick(tick), .clr(restart),
    .long_evt(long_evt), .short_evt(short_evt), .taps(taps));

  assign evt = mode_q.short_sel ? short_evt : long_evt;

  wt_req_flag u_flag (
    .clk(clk), .rst(rst), .set(evt), .clr(wt_req_clr), .flag(wt_req));

  wt_tone_mux u_mux (
    .run(mode_q.run), .tone(mode_q.tone), .taps(taps), .buzz(buzz));

  // R3: stopped timer keeps the buzzer low
  a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
    !mode_q.run |-> !buzz);

  // R3: stopped timer raises no request
  a_r3_no_req: assert property (@(posedge clk) disable iff (rst)
    (!mode_q.run && !wt_req) |=> !wt_req);

  // R2: a write is visible on readback next cycle
  a_r2_readback: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> mode_rdata == {1'b0, $past(mode_wdata[6:0])});

endmodule

// File: tb/sim_watch_buzzer_timer.sv
module sim_watch_buzzer_timer;
  localparam int CLK_P  = 10;
  localparam int PD     = 4;
  localparam int CW     = 8;
  localparam int SL     = 4;
  localparam int TL     = 1;

  logic       clk = 1'b0;
  logic       rst;
  logic       mode_we;
  logic [7:0] mode_wdata;
  logic [7:0] mode_rdata;
  logic       wt_req_clr;
  logic       wt_req;
  logic       buzz;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  watch_buzzer_timer #(.PRE_DIV(PD), .CHAIN_W(CW), .SHORT_LOG2(SL), .TAP_LO(TL)) u0 (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .mode_rdata(mode_rdata), .wt_req_clr(wt_req_clr), .wt_req(wt_req), .buzz(buzz));

  function automatic int interval_cycles(input logic short_sel);
    return short_sel ? (1 << SL) * PD : (1 << CW) * PD;
  endfunction

  function automatic int tone_period(input int t);
    return (1 << (TL + 4 - t)) * PD;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    mode_we = 1'b1; mode_wdata = d;
    @(negedge clk);
    mode_we = 1'b0; mode_wdata = '0;
  endtask

  task automatic clr_pulse();
    wt_req_clr = 1'b1;
    @(negedge clk);
    wt_req_clr = 1'b0;
  endtask

  // after a restart write, check the exact expiry edge
  task automatic expect_expiry(input string req, input int n);
    step(n - 1);
    chk(req, wt_req, 0);
    step(1);
    chk(req, wt_req, 1);
  endtask

  task automatic measure_tone(input string req, input int t);
    int guard, hi, per;
    logic prev;
    guard = 0;
    prev = buzz;
    step(1);
    while (!(buzz && !prev) && guard < 2000) begin
      prev = buzz; step(1); guard++;
    end
    hi = 0; per = 0;
    prev = buzz;
    while (guard < 4000) begin
      if (buzz) hi++;
      per++;
      step(1); guard++;
      if (buzz && !prev) break;
      prev = buzz;
    end
    chk(req, per, tone_period(t));
    chk(req, hi, tone_period(t) / 2);
  endtask

  initial begin
    #(CLK_P * 180000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int t;
    logic s;
    void'($urandom(32'd4242));
    rst = 1'b1; mode_we = 1'b0; mode_wdata = '0; wt_req_clr = 1'b0;
    step(4);
    rst = 1'b0;
    step(1);
    // R1
    chk("R1", mode_rdata, 0);
    chk("R1", wt_req, 0);
    chk("R1", buzz, 0);

    // R2 readback including reserved bits, timer stays stopped
    wr(8'h7A);
    chk("R2", mode_rdata, 8'h7A);
    // R8 restart bit not stored
    wr(8'hF4);
    chk("R8", mode_rdata, 8'h74);
    wr(8'h00);

    // R5 long interval from restart
    wr(8'h81);
    expect_expiry("R5", interval_cycles(1'b0));
    // R9 sticky, then cleared
    step(5);
    chk("R9", wt_req, 1);
    clr_pulse();
    chk("R9", wt_req, 0);

    // R3 / R4 freeze and resume
    wr(8'h81);
    step(100);
    wr(8'h00);
    step(300);
    chk("R3", wt_req, 0);
    chk("R3", buzz, 0);
    wr(8'h01);
    expect_expiry("R4", interval_cycles(1'b0) - 101);
    clr_pulse();

    // R6 short interval and R10 priority
    wr(8'h83);
    step(interval_cycles(1'b1) - 1);
    chk("R6", wt_req, 0);
    wt_req_clr = 1'b1;
    step(1);
    wt_req_clr = 1'b0;
    chk("R10", wt_req, 1);
    clr_pulse();
    chk("R9", wt_req, 0);
    expect_expiry("R6", interval_cycles(1'b1) - 1);
    clr_pulse();

    // R8 restart in mid-run delays the next expiry
    step(20);
    wr(8'h83);
    expect_expiry("R8", interval_cycles(1'b1));
    clr_pulse();

    // R7 every tone, directed
    for (int k = 0; k < 4; k++) begin
      wr(8'h81 | 8'(k << 2));
      measure_tone("R7", k);
    end

    // random tone and interval combinations
    for (int k = 0; k < 8; k++) begin
      t = int'($urandom % 4);
      s = 1'($urandom % 2);
      clr_pulse();
      d = 8'h81 | 8'(t << 2) | {6'd0, s, 1'b0};
      wr(d);
      expect_expiry(s ? "R6" : "R5", interval_cycles(s));
      chk("R2", mode_rdata, int'(d & 8'h7F));
      measure_tone("R7", t);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule